// File: doc/BRIEF.md
# DMA Global Control and Status Register Bank

This block is the shared register bank that sits between a simple 32-bit register bus and up to eight DMA channel engines. Software uses it to do four things:

- choose each channel's transfer mode and direction,
- enable per-channel interrupts,
- kick channels off with write-triggered start pulses,
- observe and acknowledge per-channel completion and error events.

The engines report three things back: a done pulse, an error pulse and a live 2-bit engine state. The bank folds the enabled interrupt flags into one interrupt line.

The bus is a single write strobe with an address and write data. Read data is a combinational function of the address. A write takes effect on the rising clock edge where the strobe is high. Five word offsets are decoded: 0x00, 0x04, 0x08, 0x10 and 0x14. Every other address reads as zero and ignores writes.

Top module: `dma_csr_bank`

## Requirements
- R1: After synchronous reset, every decoded register reads zero, and the outputs ch_mode, ch_dir, ch_irq_en, ch_start and irq are all zero.
- R2: Offset 0x00 gives channel c the nibble at bits [4c+3:4c]. Bits [4c+1:4c] hold the mode (0 off, 1 descriptor list, 2 single block, 3 stored as written), driven on ch_mode[2c+1:2c]. Bit 4c+2 holds the direction (1 memory to device, 0 device to memory), driven on ch_dir[c]. Bit 4c+3 reads as 0. Outputs follow a write from the next clock edge.
- R3: Bits [7:0] of offset 0x08 are read/write interrupt enables, one per channel, driven on ch_irq_en.
- R4: Writing 1 to bit 8+c of offset 0x08 raises ch_start[c] for exactly one cycle, starting at the clock edge of the write. Bits [15:8] read as 0.
- R5: A done pulse on ch_done[c] sets the interrupt flag at bit c of offset 0x10.
- R6: An error pulse on ch_err[c] sets both the interrupt flag at bit c and the error flag at bit c+8 of offset 0x10.
- R7: Writing offset 0x10 clears each interrupt flag or error flag whose bit in the write data is 1. Flags written with 0 are kept.
- R8: When a done or error pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Bits [16+2c+1:16+2c] of offset 0x10 show ch_state[2c+1:2c] live, with no clock delay.
- R10: irq is high exactly when some channel has its interrupt flag and its enable bit both set.
- R11: Offsets 0x04 and 0x14 are plain 32-bit read/write storage.
- R12: Any address other than the five decoded offsets reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ch_mode | output | 2*NUM_CH | Per-channel transfer mode |
| ch_dir | output | NUM_CH | Per-channel direction, 1 = memory to device |
| ch_irq_en | output | NUM_CH | Per-channel interrupt enable |
| ch_start | output | NUM_CH | One-cycle start pulses |
| ch_done | input | NUM_CH | Per-channel completion pulses |
| ch_err | input | NUM_CH | Per-channel error pulses |
| ch_state | input | 2*NUM_CH | Per-channel engine state |
| irq | output | 1 | Combined interrupt |

## Verification
A flag held wrongly shows at bus_rdata at offset 0x10 in the cycle after the event. When that channel is enabled, it also shows on irq in that same cycle.

A start bit that sticks or is dropped shows on ch_start one cycle after the write. A start pulse that lasts too long is exposed by checking the cycle after that as well.

A mis-decoded configuration nibble shows at once on ch_mode and ch_dir after the write edge. It also shows on the readback of offset 0x00.

The set-versus-clear race is driven in a single cycle, so a wrong priority appears in the very next readback.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int MAX_CH = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_AUX0  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IENST = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FLAGS = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_AUX1  = 8'h14;

    localparam int NIB_W      = 4;
    localparam int START_LSB  = 8;
    localparam int ERR_LSB    = 8;
    localparam int STATE_LSB  = 16;

    typedef enum logic [1:0] {
        XFER_OFF    = 2'd0,
        XFER_LIST   = 2'd1,
        XFER_SINGLE = 2'd2,
        XFER_RSVD   = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       to_dev;
    } chan_cfg_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_wr_t;

    function automatic logic [NIB_W-1:0] pack_nibble(chan_cfg_t c);
        return {1'b0, c.to_dev, c.mode};
    endfunction

endpackage

// File: rtl/csr_ctrl_regs.sv
module csr_ctrl_regs
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_wr_t             wr,
    output chan_cfg_t           cfg_q [NUM_CH],
    output logic [NUM_CH-1:0]   ien_q,
    output logic [NUM_CH-1:0]   start_q,
    output logic [DATA_W-1:0]   aux0_q,
    output logic [DATA_W-1:0]   aux1_q
);

    logic mode_wr, ienst_wr;
    assign mode_wr  = wr.we && (wr.addr == OFS_MODE);
    assign ienst_wr = wr.we && (wr.addr == OFS_IENST);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[c]   <= '{mode: XFER_OFF, to_dev: 1'b0};
                ien_q[c]   <= 1'b0;
                start_q[c] <= 1'b0;
            end else begin
                if (mode_wr) begin
                    cfg_q[c].mode   <= xfer_mode_e'(wr.wdata[NIB_W*c +: 2]);
                    cfg_q[c].to_dev <= wr.wdata[NIB_W*c + 2];
                end
                if (ienst_wr) begin
                    ien_q[c] <= wr.wdata[c];
                end
                start_q[c] <= ienst_wr && wr.wdata[START_LSB + c];
            end
        end

        assert_start_origin_R4: assert property (@(posedge clk) disable iff (rst)
            start_q[c] |-> ($past(ienst_wr) && $past(wr.wdata[START_LSB + c])));

        assert_mode_stable_R2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(mode_wr)) |-> $stable(cfg_q[c]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aux0_q <= '0;
            aux1_q <= '0;
        end else if (wr.we) begin
            if (wr.addr == OFS_AUX0) aux0_q <= wr.wdata;
            if (wr.addr == OFS_AUX1) aux1_q <= wr.wdata;
        end
    end

endmodule

// File: rtl/csr_status_flags.sv
module csr_status_flags
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] clr_irq,
    input  logic [NUM_CH-1:0] clr_err,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_err,
    output logic [NUM_CH-1:0] irq_flag,
    output logic [NUM_CH-1:0] err_flag
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic set_irq;
        assign set_irq = ch_done[c] | ch_err[c];

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_flag[c] <= 1'b0;
                err_flag[c] <= 1'b0;
            end else begin
                if (set_irq)          irq_flag[c] <= 1'b1;
                else if (clr_irq[c])  irq_flag[c] <= 1'b0;
                if (ch_err[c])        err_flag[c] <= 1'b1;
                else if (clr_err[c])  err_flag[c] <= 1'b0;
            end
        end

        assert_set_priority_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(ch_done[c] || ch_err[c])) |-> irq_flag[c]);

        assert_err_sets_irq_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(err_flag[c]) |-> irq_flag[c]);

        assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(clr_irq[c] && !ch_done[c] && !ch_err[c]))
                |-> !irq_flag[c]);
    end

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  chan_cfg_t           cfg_q [NUM_CH],
    input  logic [NUM_CH-1:0]   ien_q,
    input  logic [DATA_W-1:0]   aux0_q,
    input  logic [DATA_W-1:0]   aux1_q,
    input  logic [NUM_CH-1:0]   irq_flag,
    input  logic [NUM_CH-1:0]   err_flag,
    input  logic [2*NUM_CH-1:0] ch_state,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mode_word, ienst_word, flag_word;

    always_comb begin
        mode_word  = '0;
        ienst_word = '0;
        flag_word  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            mode_word[NIB_W*c +: NIB_W]   = pack_nibble(cfg_q[c]);
            ienst_word[c]                 = ien_q[c];
            flag_word[c]                  = irq_flag[c];
            flag_word[ERR_LSB + c]        = err_flag[c];
            flag_word[STATE_LSB + 2*c +: 2] = ch_state[2*c +: 2];
        end
    end

    always_comb begin
        unique case (addr)
            OFS_MODE:  rdata = mode_word;
            OFS_AUX0:  rdata = aux0_q;
            OFS_IENST: rdata = ienst_word;
            OFS_FLAGS: rdata = flag_word;
            OFS_AUX1:  rdata = aux1_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [2*NUM_CH-1:0] ch_mode,
    output logic [NUM_CH-1:0]   ch_dir,
    output logic [NUM_CH-1:0]   ch_irq_en,
    output logic [NUM_CH-1:0]   ch_start,
    input  logic [NUM_CH-1:0]   ch_done,
    input  logic [NUM_CH-1:0]   ch_err,
    input  logic [2*NUM_CH-1:0] ch_state,
    output logic                irq
);

    bus_wr_t           wr;
    chan_cfg_t         cfg_q [NUM_CH];
    logic [NUM_CH-1:0] ien_q, start_q, irq_flag, err_flag, clr_irq, clr_err;
    logic [DATA_W-1:0] aux0_q, aux1_q;
    logic              flags_wr;

    assign wr       = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign flags_wr = bus_we && (bus_addr == OFS_FLAGS);
    assign clr_irq  = flags_wr ? bus_wdata[NUM_CH-1:0] : '0;
    assign clr_err  = flags_wr ? bus_wdata[ERR_LSB +: NUM_CH] : '0;

    csr_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk(clk), .rst(rst), .wr(wr), .cfg_q(cfg_q), .ien_q(ien_q),
        .start_q(start_q), .aux0_q(aux0_q), .aux1_q(aux1_q)
    );

    csr_status_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk(clk), .rst(rst), .clr_irq(clr_irq), .clr_err(clr_err),
        .ch_done(ch_done), .ch_err(ch_err),
        .irq_flag(irq_flag), .err_flag(err_flag)
    );

    csr_read_mux #(.NUM_CH(NUM_CH)) u_rmux (
        .addr(bus_addr), .cfg_q(cfg_q), .ien_q(ien_q), .aux0_q(aux0_q),
        .aux1_q(aux1_q), .irq_flag(irq_flag), .err_flag(err_flag),
        .ch_state(ch_state), .rdata(bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign ch_mode[2*c +: 2] = cfg_q[c].mode;
        assign ch_dir[c]         = cfg_q[c].to_dev;
    end

    assign ch_irq_en = ien_q;
    assign ch_start  = start_q;
    assign irq       = |(irq_flag & ien_q);

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((|irq_flag) && (|ch_irq_en)));

    initial begin
        assert_ch_count_R2: assert (NUM_CH >= 1 && NUM_CH <= MAX_CH);
    end

endmodule

// File: tb/sim_dma_csr_bank.sv
module sim_dma_csr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int NV = 8;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'hFFFF_FFFF, 32'h7777_7777},
        '{8'h00, 32'h1234_5678, 32'h1234_5670},
        '{8'h04, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{8'h14, 32'hCAFE_F00D, 32'hCAFE_F00D},
        '{8'h08, 32'h0000_A5C3, 32'h0000_00C3},
        '{8'h08, 32'hFFFF_FF3C, 32'h0000_003C},
        '{8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
        '{8'h20, 32'h1234_5678, 32'h0000_0000}
    };

    logic clk = 0, rst = 1, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [2*N-1:0] ch_mode, ch_state = 0;
    logic [N-1:0] ch_dir, ch_irq_en, ch_start, ch_done = 0, ch_err = 0;
    logic irq;
    int checks = 0, fails = 0;
    bit finished = 0;
    string vtag [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_csr_bank #(.NUM_CH(N)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_mode(ch_mode),
        .ch_dir(ch_dir), .ch_irq_en(ch_irq_en), .ch_start(ch_start),
        .ch_done(ch_done), .ch_err(ch_err), .ch_state(ch_state), .irq(irq)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic read_check(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(logic [N-1:0] d, logic [N-1:0] e);
        @(negedge clk);
        ch_done = d; ch_err = e;
        @(negedge clk);
        ch_done = 0; ch_err = 0;
    endtask

    initial begin
        logic [31:0] mv;
        logic [2*N-1:0] em;
        logic [N-1:0] ed;
        vtag = '{"R2", "R2", "R11", "R11", "R3", "R3", "R12", "R12"};
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        read_check("R1 mode", 8'h00, 0);
        read_check("R1 aux0", 8'h04, 0);
        read_check("R1 ienst", 8'h08, 0);
        read_check("R1 flags", 8'h10, 0);
        read_check("R1 aux1", 8'h14, 0);
        check("R1 outs", {ch_mode, ch_dir, ch_irq_en, ch_start, irq}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].wdata);
            read_check(vtag[i], VECS[i].addr, VECS[i].rexp);
        end

        // R12 unmapped writes left mapped registers alone
        read_check("R12 mode kept", 8'h00, 32'h1234_5670);
        read_check("R12 aux0 kept", 8'h04, 32'hDEAD_BEEF);
        read_check("R12 ien kept", 8'h08, 32'h0000_003C);
        read_check("R12 odd addr", 8'h01, 0);

        // R2 outputs decoded from the nibbles
        mv = 32'h1234_5670;
        em = 0; ed = 0;
        for (int c = 0; c < N; c++) begin
            em[2*c +: 2] = mv[4*c +: 2];
            ed[c]        = mv[4*c + 2];
        end
        check("R2 ch_mode", 32'(ch_mode), 32'(em));
        check("R2 ch_dir", 32'(ch_dir), 32'(ed));

        // R4 start pulse lasts one cycle, R3 enables from same write
        do_write(8'h08, 32'h0000_8100);
        check("R4 start high", 32'(ch_start), 32'h81);
        check("R3 ien", 32'(ch_irq_en), 32'h00);
        @(negedge clk);
        check("R4 start low", 32'(ch_start), 0);
        read_check("R4 readback", 8'h08, 0);

        // R9 live state
        ch_state = 16'hE41B;
        read_check("R9 state", 8'h10, 32'hE41B_0000);
        ch_state = 0;

        // R5 / R10
        do_write(8'h08, 32'h0000_000F);
        pulse(8'h05, 8'h00);
        read_check("R5 done", 8'h10, 32'h0000_0005);
        check("R10 irq on", 32'(irq), 1);

        // R6 error sets both
        pulse(8'h00, 8'h80);
        read_check("R6 err", 8'h10, 32'h0000_8085);

        // R7 write one to clear
        do_write(8'h10, 32'h0000_0001);
        read_check("R7 clr0", 8'h10, 32'h0000_8084);
        check("R10 irq still", 32'(irq), 1);
        do_write(8'h10, 32'h0000_0004);
        read_check("R7 clr2", 8'h10, 32'h0000_8080);
        check("R10 masked", 32'(irq), 0);
        do_write(8'h10, 32'hFFFF_8000);
        read_check("R7 clr err", 8'h10, 32'h0000_0080);

        // R8 set beats clear
        @(negedge clk);
        bus_we = 1; bus_addr = 8'h10; bus_wdata = 32'h0000_0082;
        ch_done = 8'h02;
        @(negedge clk);
        bus_we = 0; ch_done = 0;
        read_check("R8 race", 8'h10, 32'h0000_0002);
        check("R10 irq race", 32'(irq), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=%h exp=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule